// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the programmed settings of a clock synthesizer. The settings are a 9-bit loop divide value M, a 2-bit output divide select N and a 2-bit test select T. They can be written from parallel pins or from a three-wire serial port made of data, serial clock and load strobe. A mode pin picks between the two. While the mode pin is low the parallel pins are transparent, and the rising edge of the mode pin freezes them. While the mode pin is high the serial port shifts a 14-bit frame. The strobe either commits that frame at once or, when held high, lets every serial clock pass straight through to the settings.

The serial pins are not used as clocks. Each of them is brought into the system clock domain through a two-flop synchroniser followed by an edge detector, and every serial event acts on the system clock. The block also contains a small model of the two dividers, both counting system clocks. The feedback divider output and the divided output clock can both be routed to a test pin. An active-high master reset clears the divider counters and holds the outputs at rest, and it leaves the stored settings untouched. A flag reports a stored M outside the lockable window.

Top module: `synth_cfg_loader`

## Requirements
- R1: After `rst_n` is released, M=20, N=0 and T=0. While `par_latch` is low, `m_val` and `n_val` take `par_m` and `par_n` on the next rising system clock.
- R2: While `par_latch` stays high and no serial event occurs, `m_val` and `n_val` hold their values whatever `par_m` and `par_n` do.
- R3: With `par_latch` high, each rising serial clock shifts `sdat` into the LSB of a 14-bit shift register. A rising strobe copies bits [13:12] to T, bits [10:9] to N and bits [8:0] to M. Bit 11 is a null slot and is ignored. The shift order is therefore T1, T0, null, N1, N0, M8 down to M0.
- R4: While the strobe is held high, each rising serial clock also updates M, N and T from the shift register as it stands after that shift.
- R5: After the strobe falls, serial clocks with the strobe low shift data but leave M, N and T unchanged.
- R6: Parallel loading never changes T.
- R7: With `par_latch` high, `test_out` follows T: 00 gives 0, 01 gives the synchronised `sdat`, 10 gives the feedback divider output, and 11 gives `fout`. The feedback divider output is high for the first floor(M/2) counts of each M-count cycle (M below 2 counts as 2).
- R8: `test_out` is 0 whenever `par_latch` is low.
- R9: While `mr` is high, `fout` is 0 and `fout_n` is 1, and M, N and T are unchanged. Once `mr` is low again, the first toggle of `fout` comes on the 2^N-th rising clock.
- R10: `fout` toggles every 2^N system clocks (N=00,01,10,11 give 1,2,4,8), and `fout_n` is always its inverse.
- R11: `m_range_err` is 1 exactly when the stored M is below 10 or above 28.
- R12: A change on `sclk`, `sstb` or `sdat` takes effect on the third rising system clock after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr | input | 1 | Master reset for the dividers, active high |
| par_latch | input | 1 | Low: parallel pins transparent; high: latched / serial mode |
| par_m | input | 9 | Parallel M value |
| par_n | input | 2 | Parallel N select |
| sclk | input | 1 | Serial clock |
| sdat | input | 1 | Serial data |
| sstb | input | 1 | Serial load strobe |
| m_val | output | 9 | Stored M |
| n_val | output | 2 | Stored N |
| t_val | output | 2 | Stored T |
| test_out | output | 1 | Test pin |
| fout | output | 1 | Divided output clock |
| fout_n | output | 1 | Inverse of fout |
| m_range_err | output | 1 | Stored M outside 10..28 |

## Verification
The assertions take for granted that a strobe edge and a serial clock edge never reach the synchronisers in the same system cycle. They also assume that `sdat` stays still across each rising serial clock. The stimulus follows both rules. It changes data only while the serial clock is low and holds each serial level for at least three system clocks, so every edge is seen once and settles cleanly. The parallel and mode pins change just after a clock edge, which keeps their effect inside a single known cycle.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [1:0] {
    TSEL_LOW  = 2'b00,
    TSEL_ECHO = 2'b01,
    TSEL_FB   = 2'b10,
    TSEL_OUT  = 2'b11
  } tsel_e;
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise
);
  logic [W-1:0] stage [STAGES+1];
  logic [W-1:0] q_prev;

  assign stage[0] = d;

  genvar g;
  generate
    for (g = 1; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= stage[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_prev <= '0;
    else        q_prev <= stage[STAGES];
  end

  assign q    = stage[STAGES];
  assign rise = stage[STAGES] & ~q_prev;

  // an edge report lasts a single cycle
  p_rise_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/cfgld_regs.sv
module cfgld_regs #(
  parameter int M_W   = 9,
  parameter int N_W   = 2,
  parameter int T_W   = 2,
  parameter int M_RST = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_latch,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           clk_rise,
  input  logic           stb_rise,
  input  logic           stb_lvl,
  input  logic           sdata,
  output logic [M_W-1:0] m_q,
  output logic [N_W-1:0] n_q,
  output logic [T_W-1:0] t_q
);
  localparam int FW    = T_W + 1 + N_W + M_W;
  localparam int FM_LO = 0;
  localparam int FN_LO = M_W;
  localparam int FT_LO = M_W + N_W + 1;

  logic [FW-1:0] sr;
  logic          do_shift;
  logic          commit;
  logic          pass_thru;

  assign do_shift  = par_latch & clk_rise;
  assign commit    = par_latch & stb_rise;
  assign pass_thru = par_latch & stb_lvl & clk_rise & ~stb_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else if (do_shift) sr <= {sr[FW-2:0], sdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= M_W'(M_RST);
      n_q <= '0;
      t_q <= '0;
    end else if (!par_latch) begin
      m_q <= par_m;
      n_q <= par_n;
    end else if (commit) begin
      m_q <= sr[FM_LO +: M_W];
      n_q <= sr[FN_LO +: N_W];
      t_q <= sr[FT_LO +: T_W];
    end else if (pass_thru) begin
      m_q <= {sr[M_W-2:0], sdata};
      n_q <= sr[FN_LO-1 +: N_W];
      t_q <= sr[FT_LO-1 +: T_W];
    end
  end

  p_par_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(par_latch)) |-> (m_q == $past(par_m) && n_q == $past(par_n)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(par_latch) && !$past(stb_rise) && !$past(clk_rise))
      |-> ($stable(m_q) && $stable(n_q) && $stable(t_q)));

  p_frame_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(par_latch) && $past(stb_rise))
      |-> (m_q == $past(sr[FM_LO +: M_W]) && t_q == $past(sr[FT_LO +: T_W])));

  p_t_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(par_latch)) |-> $stable(t_q));
endmodule

// File: rtl/cfgld_divider.sv
module cfgld_divider #(
  parameter int M_W = 9,
  parameter int N_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mr,
  input  logic [M_W-1:0] m_set,
  input  logic [N_W-1:0] n_set,
  output logic           fb_out,
  output logic           clk_out
);
  localparam int R_W = 2 ** N_W;

  logic [M_W-1:0] mcnt;
  logic [M_W-1:0] mlim;
  logic [R_W-1:0] ocnt;
  logic [R_W-1:0] ratio;
  logic           oclk;

  assign mlim  = (m_set < M_W'(2)) ? M_W'(2) : m_set;
  assign ratio = R_W'(1) << n_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      mcnt <= '0;
    else if (mr)                     mcnt <= '0;
    else if (mcnt >= mlim - 1'b1)    mcnt <= '0;
    else                             mcnt <= mcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocnt <= '0;
      oclk <= 1'b0;
    end else if (mr) begin
      ocnt <= '0;
      oclk <= 1'b0;
    end else if (ocnt >= ratio - 1'b1) begin
      ocnt <= '0;
      oclk <= ~oclk;
    end else begin
      ocnt <= ocnt + 1'b1;
    end
  end

  assign fb_out  = (mcnt < (mlim >> 1));
  assign clk_out = oclk;

  p_mr_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mr) |-> (mcnt == '0 && ocnt == '0 && !oclk));

  p_ocnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(n_set)) |-> (ocnt < ratio));
endmodule

// File: rtl/cfgld_testmux.sv
module cfgld_testmux (
  input  logic       par_latch,
  input  logic [1:0] tsel,
  input  logic       echo_in,
  input  logic       fb_in,
  input  logic       out_in,
  output logic       test_out
);
  import cfgld_pkg::*;

  tsel_e sel;
  assign sel = tsel_e'(tsel);

  always_comb begin
    test_out = 1'b0;
    if (par_latch) begin
      unique case (sel)
        TSEL_LOW:  test_out = 1'b0;
        TSEL_ECHO: test_out = echo_in;
        TSEL_FB:   test_out = fb_in;
        TSEL_OUT:  test_out = out_in;
        default:   test_out = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader #(
  parameter int M_W         = 9,
  parameter int N_W         = 2,
  parameter int T_W         = 2,
  parameter int SYNC_STAGES = 2,
  parameter int M_RST       = 20,
  parameter int M_MIN       = 10,
  parameter int M_MAX       = 28
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mr,
  input  logic           par_latch,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           sclk,
  input  logic           sdat,
  input  logic           sstb,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_val,
  output logic [T_W-1:0] t_val,
  output logic           test_out,
  output logic           fout,
  output logic           fout_n,
  output logic           m_range_err
);
  localparam int SI_CLK = 0;
  localparam int SI_STB = 1;
  localparam int SI_DAT = 2;
  localparam int SI_W   = 3;

  logic [SI_W-1:0] s_q;
  logic [SI_W-1:0] s_rise;
  logic            fb_raw;
  logic            oclk_raw;

  cfgld_sync #(.W(SI_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sdat, sstb, sclk}),
    .q    (s_q),
    .rise (s_rise)
  );

  cfgld_regs #(.M_W(M_W), .N_W(N_W), .T_W(T_W), .M_RST(M_RST)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_latch(par_latch),
    .par_m    (par_m),
    .par_n    (par_n),
    .clk_rise (s_rise[SI_CLK]),
    .stb_rise (s_rise[SI_STB]),
    .stb_lvl  (s_q[SI_STB]),
    .sdata    (s_q[SI_DAT]),
    .m_q      (m_val),
    .n_q      (n_val),
    .t_q      (t_val)
  );

  cfgld_divider #(.M_W(M_W), .N_W(N_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .mr     (mr),
    .m_set  (m_val),
    .n_set  (n_val),
    .fb_out (fb_raw),
    .clk_out(oclk_raw)
  );

  assign fout   = oclk_raw & ~mr;
  assign fout_n = ~fout;

  cfgld_testmux u_tmux (
    .par_latch(par_latch),
    .tsel     (t_val[1:0]),
    .echo_in  (s_q[SI_DAT]),
    .fb_in    (fb_raw),
    .out_in   (fout),
    .test_out (test_out)
  );

  assign m_range_err = (m_val < M_W'(M_MIN)) || (m_val > M_W'(M_MAX));

  p_test_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !par_latch |-> !test_out);

  p_mr_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mr |-> (!fout && fout_n));

  p_mr_keeps_m_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mr) && $past(par_latch) && !$past(s_rise[SI_STB]) && !$past(s_rise[SI_CLK]))
      |-> $stable(m_val));

  p_fout_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fout != fout_n);
endmodule

// File: tb/synth_cfg_loader_bench.sv
`timescale 1ns/1ps
module synth_cfg_loader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mr = 1'b0;
  logic par_latch = 1'b0;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic sclk = 1'b0, sdat = 1'b0, sstb = 1'b0;
  logic [8:0] m_val;
  logic [1:0] n_val, t_val;
  logic test_out, fout, fout_n, m_range_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  synth_cfg_loader u_synth_cfg_loader (
    .clk(clk), .rst_n(rst_n), .mr(mr), .par_latch(par_latch),
    .par_m(par_m), .par_n(par_n), .sclk(sclk), .sdat(sdat), .sstb(sstb),
    .m_val(m_val), .n_val(n_val), .t_val(t_val), .test_out(test_out),
    .fout(fout), .fout_n(fout_n), .m_range_err(m_range_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mm, nn, tt;
  bit [13:0] msr;
  bit c_h[$], s_h[$], d_h[$];
  int mcnt, ocnt;
  bit oclk;

  function automatic int mlimit(int m);
    return (m < 2) ? 2 : m;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm = 20; nn = 0; tt = 0; msr = '0;
      c_h = '{0, 0, 0}; s_h = '{0, 0, 0}; d_h = '{0, 0};
      mcnt = 0; ocnt = 0; oclk = 0;
    end else begin
      bit crise, srise, slvl, dv;
      int lim;
      bit [13:0] nsr;
      crise = c_h[1] && !c_h[2];
      srise = s_h[1] && !s_h[2];
      slvl  = s_h[1];
      dv    = d_h[1];
      lim   = mlimit(mm);
      if (mr) begin mcnt = 0; ocnt = 0; oclk = 0; end
      else begin
        mcnt = (mcnt >= lim - 1) ? 0 : mcnt + 1;
        if (ocnt >= (1 << nn) - 1) begin ocnt = 0; oclk = !oclk; end
        else ocnt = ocnt + 1;
      end
      nsr = {msr[12:0], dv};
      if (!par_latch) begin mm = par_m; nn = par_n; end
      else if (srise) begin mm = msr[8:0]; nn = msr[10:9]; tt = msr[13:12]; end
      else if (slvl && crise) begin mm = nsr[8:0]; nn = nsr[10:9]; tt = nsr[13:12]; end
      if (par_latch && crise) msr = nsr;
      c_h.push_front(sclk); void'(c_h.pop_back());
      s_h.push_front(sstb); void'(s_h.pop_back());
      d_h.push_front(sdat); void'(d_h.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_fout, exp_test;
      exp_fout = (oclk && !mr) ? 1 : 0;
      if (!par_latch) exp_test = 0;
      else case (tt)
        0: exp_test = 0;
        1: exp_test = d_h[1];
        2: exp_test = (mcnt < mlimit(mm) / 2) ? 1 : 0;
        default: exp_test = exp_fout;
      endcase
      chk("R1 R3 R4 m_val model", m_val, mm);
      chk("R1 R3 R4 n_val model", n_val, nn);
      chk("R3 R6 t_val model", t_val, tt);
      chk("R7 R8 test_out model", test_out, exp_test);
      chk("R9 R10 fout model", fout, exp_fout);
      chk("R10 fout_n model", fout_n, !exp_fout);
      chk("R11 range model", m_range_err, (mm < 10 || mm > 28) ? 1 : 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sample;
    @(negedge clk);
    #0.5;
  endtask

  bit [13:0] exp_sr = '0;

  task automatic send_bit(input bit b);
    sdat = b; step(3);
    sclk = 1'b1; step(4);
    sclk = 1'b0; step(3);
    exp_sr = {exp_sr[12:0], b};
  endtask

  task automatic send_frame(input bit [13:0] f);
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic strobe;
    sstb = 1'b1; step(5);
    sstb = 1'b0; step(5);
  endtask

  function automatic bit [13:0] mk(input bit [1:0] t, input bit nul, input bit [1:0] n, input bit [8:0] m);
    return {t, nul, n, m};
  endfunction

  task automatic period_of_fout(output int cnt);
    logic prev;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); prev = fout;
      while (fout == prev) @(negedge clk);
    end
    prev = fout; cnt = 0;
    do begin @(negedge clk); cnt++; end while (fout == prev);
    #1;
  endtask

  initial begin : watchdog
    #(150000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int per;
    step(3);
    rst_n = 1'b1;
    #0.5; sample;
    chk("R1 reset M", m_val, 20);
    chk("R1 reset N", n_val, 0);
    chk("R1 reset T", t_val, 0);
    chk("R8 reset test pin", test_out, 0);
    step(1);

    // R1 transparent parallel path
    par_m = 9'd25; par_n = 2'd1; step(1);
    sample; chk("R1 follow M", m_val, 25); chk("R1 follow N", n_val, 1);
    step(1);

    // R2 latch on rising par_latch
    par_latch = 1'b1; step(1);
    par_m = 9'd7; par_n = 2'd3; step(6);
    sample; chk("R2 held M", m_val, 25); chk("R2 held N", n_val, 1);
    step(1);

    // R3 frame with T=01, null=1, N=10, M=12
    send_frame(mk(2'b01, 1'b1, 2'b10, 9'd12));
    sample; chk("R5 no commit before strobe", m_val, 25);
    step(1);
    strobe;
    sample;
    chk("R3 frame M", m_val, 12); chk("R3 frame N", n_val, 2); chk("R3 frame T", t_val, 1);
    step(1);

    // R7 echo select
    sdat = 1'b1; step(3); sample; chk("R7 echo high", test_out, 1);
    step(1);
    sdat = 1'b0; step(3); sample; chk("R7 echo low", test_out, 0);
    step(1);

    // R5 shifts with strobe low do not reach settings
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    sample; chk("R5 M unchanged", m_val, 12); chk("R5 T unchanged", t_val, 1);
    step(1);

    // R12 latency of strobe rising, then R4 pass-through with strobe held high
    sstb = 1'b1; step(2);
    sample; chk("R12 not yet loaded", m_val, 12);
    step(1);
    sample; chk("R12 loaded on third edge", m_val, int'(exp_sr[8:0]));
    step(1);
    send_bit(1'b1);
    sample;
    chk("R4 pass-through M", m_val, int'(exp_sr[8:0]));
    chk("R4 pass-through N", n_val, int'(exp_sr[10:9]));
    chk("R4 pass-through T", t_val, int'(exp_sr[13:12]));
    step(1);
    sstb = 1'b0; step(4);

    // R6 and R8: parallel mode keeps T and forces the test pin low
    send_frame(mk(2'b01, 1'b0, 2'b00, 9'd14)); strobe;
    sdat = 1'b1; step(4);
    par_latch = 1'b0; par_m = 9'd16; par_n = 2'd2; step(1);
    sample; chk("R8 test low in parallel", test_out, 0);
    chk("R6 T kept", t_val, 1); chk("R1 M from pins", m_val, 16);
    step(1);
    sdat = 1'b0;

    // R10 output divide ratios
    for (int n = 0; n < 4; n++) begin
      par_n = 2'(n); step(2);
      period_of_fout(per);
      chk("R10 fout toggle interval", per, 1 << n);
    end

    // R11 range flag at the window edges
    par_m = 9'd9;  step(1); sample; chk("R11 M=9 flagged", m_range_err, 1); step(1);
    par_m = 9'd10; step(1); sample; chk("R11 M=10 ok", m_range_err, 0); step(1);
    par_m = 9'd28; step(1); sample; chk("R11 M=28 ok", m_range_err, 0); step(1);
    par_m = 9'd29; step(1); sample; chk("R11 M=29 flagged", m_range_err, 1); step(1);

    // R9 master reset with N=2 (toggle every 4)
    par_m = 9'd12; par_n = 2'd2; step(2);
    par_latch = 1'b1; step(2);
    mr = 1'b1; step(1);
    sample; chk("R9 fout low", fout, 0); chk("R9 fout_n high", fout_n, 1);
    step(3);
    sample; chk("R9 M kept", m_val, 12);
    step(1);
    mr = 1'b0; step(3);
    sample; chk("R9 no toggle before 4th edge", fout, 0);
    step(1);
    sample; chk("R9 first toggle on 4th edge", fout, 1);
    step(1);

    // R7 feedback divider and output clock on the test pin
    send_frame(mk(2'b10, 1'b0, 2'b01, 9'd12)); strobe;
    begin
      int hi = 0;
      for (int k = 0; k < 12; k++) begin sample; hi += test_out; end
      chk("R7 feedback high count M=12", hi, 6);
    end
    step(1);
    send_frame(mk(2'b11, 1'b0, 2'b01, 9'd12)); strobe;
    for (int k = 0; k < 4; k++) begin sample; chk("R7 test equals fout", test_out, fout); end
    step(1);
    send_frame(mk(2'b00, 1'b0, 2'b01, 9'd12)); strobe;
    sample; chk("R7 select 00 low", test_out, 0);
    step(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule